// File: doc/BRIEF.md
# Tributary Transmit Elastic Store

This block sits between a DS1/E1-rate tributary source and a mapper that runs on local STS-1 timing. The tributary side pushes data with a gapped write enable. The mapper side pulls data with its own read enable. Both sides share one clock, and the rate difference appears only in the pattern of the two enables. The block reports its fill level so that a downstream justification or pointer controller can decide when to stuff. Overflow and underflow are recorded as sticky flags. A recovery recentres the store so that it can absorb further drift in either direction.

One 64-cell storage array serves two organisations, chosen by a two-bit mode input. In the asynchronous mode (code 2'b00) and the bit-synchronous mode (code 2'b01), the array is a 64-deep single-bit FIFO. In the byte-synchronous modes (codes 2'b10 and 2'b11), the same cells form an 8-entry byte FIFO. Each byte entry carries a marker bit that tags the byte holding the V5 overhead position.

A small controller owns the organisation. It has three states:
- **ST_FLUSH** clears the store and latches the mode.
- **ST_BIT** runs the single-bit FIFO.
- **ST_BYTE** runs the byte FIFO with markers.

The controller has four transitions. Reset enters ST_FLUSH. ST_FLUSH always moves to ST_BYTE when bit 1 of the mode input is 1, and to ST_BIT otherwise. ST_BIT or ST_BYTE returns to ST_FLUSH when the mode input differs from the latched mode.

Top module: `trib_elastic_store`

## Requirements
- R1: In modes 2'b00 and 2'b01, the store holds up to 64 single bits. `fill_o` reaches 64 after 64 writes. Reads return the bits in the order they were written, on `rd_bit_o`.
- R2: In modes 2'b10 and 2'b11, the store holds up to 8 bytes. Each byte has a marker bit. Reads return each byte on `rd_byte_o` and its marker on `rd_mark_o`, in write order. `fill_o` peaks at 8.
- R3: Overflow is a write while the store is full with no read in the same cycle. On overflow, the written value is dropped and `ovf_o` sets. `fill_o` becomes half the depth (32 or 4). Reading then resumes at the entry written half a depth before the current write position. A write and a read together on a full store are both accepted, and no overflow is raised.
- R4: Underflow is a read while the store is empty. On underflow, `unf_o` sets and the read outputs keep their previous value. `fill_o` becomes half the depth. A write in the same cycle is discarded.
- R5: Outside overflow and underflow, `fill_o` rises by one on an accepted write. It falls by one on an accepted read. It does not change when both happen in the same cycle.
- R6: `ovf_o` and `unf_o` stay set until cleared. Writing 1 to `clr_i[0]` clears `ovf_o`. Writing 1 to `clr_i[1]` clears `unf_o`. A new event in the same cycle as a clear wins over the clear.
- R7: Any change of `mode_i` flushes the store. The flush sets `fill_o` to 0, clears both flags and zeroes the read outputs. Writes and reads are ignored in the cycle the change is seen and in the following ST_FLUSH cycle.
- R8: After reset, `fill_o`, both flags and all read outputs are 0. Enables in the first cycle after reset release are ignored.
- R9: Read data appears on the outputs on the clock edge that accepts the read. The read outputs do not change in any cycle without an accepted read, except when a flush occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Mapping mode: 00 asynchronous, 01 bit-synchronous, 1x byte-synchronous |
| wr_en_i | input | 1 | Write strobe from the tributary side |
| wr_bit_i | input | 1 | Serial data bit, used in the bit organisation |
| wr_byte_i | input | 8 | Data byte, used in the byte organisation |
| wr_mark_i | input | 1 | Marker tag for the byte being written |
| rd_en_i | input | 1 | Read strobe from the mapper side |
| clr_i | input | 2 | Write-one-to-clear: bit 0 clears overflow, bit 1 clears underflow |
| rd_bit_o | output | 1 | Last serial bit read |
| rd_byte_o | output | 8 | Last byte read |
| rd_mark_o | output | 1 | Marker of the last byte read |
| fill_o | output | 7 | Number of stored entries (0 to 64 or 0 to 8) |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
A wrong pointer or a wrong fill count shows at the ports on the next read. The read data comes out in the wrong order, or `fill_o` drifts from the count of accepted writes minus reads, one cycle after the faulty edge. A recentre that picks the wrong resume point shows as a wrong value on the first read after an overflow. A controller stuck in ST_FLUSH, or one that skips it, shows in two cycles after a mode change: stale fill or flags remain, or enables that should be ignored are counted. A sticky flag that clears by itself, or that ignores the clear mask, shows on the next sample.

// File: rtl/tes_pkg.sv
package tes_pkg;

    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_BIT   = 2'd1,
        ST_BYTE  = 2'd2
    } tes_state_e;

    localparam logic [1:0] MODE_ASYNC    = 2'b00;
    localparam logic [1:0] MODE_BITSYNC  = 2'b01;
    localparam logic [1:0] MODE_BYTESYNC = 2'b10;

    // Bit 1 of the mode code selects the byte organisation.
    function automatic logic mode_is_byte(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/tes_ctrl.sv
module tes_ctrl
    import tes_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    output logic       flush_o,
    output logic       byte_mode_o
);

    tes_state_e state_q, state_d;
    logic [1:0] mode_q;
    logic       mode_moved;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLUSH;
        else        state_q <= state_d;
    end

    // The mode is latched only while flushing.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mode_q <= MODE_ASYNC;
        else if (state_q == ST_FLUSH) mode_q <= mode_i;
    end

    assign mode_moved = (state_q != ST_FLUSH) && (mode_i != mode_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: state_d = mode_is_byte(mode_i) ? ST_BYTE : ST_BIT;
            ST_BIT:   if (mode_moved) state_d = ST_FLUSH;
            ST_BYTE:  if (mode_moved) state_d = ST_FLUSH;
            default:  state_d = ST_FLUSH;
        endcase
    end

    // Outputs.
    always_comb begin
        flush_o     = 1'b0;
        byte_mode_o = 1'b0;
        unique case (state_q)
            ST_FLUSH: flush_o = 1'b1;
            ST_BIT:   flush_o = mode_moved;
            ST_BYTE: begin
                flush_o     = mode_moved;
                byte_mode_o = 1'b1;
            end
            default:  flush_o = 1'b1;
        endcase
    end

    // R7: the flush state lasts exactly one cycle.
    p_flush_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q != ST_FLUSH));

    // R2: the byte organisation runs only under a latched byte mode.
    p_byte_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYTE) |-> mode_is_byte(mode_q));

endmodule

// File: rtl/tes_ptr.sv
module tes_ptr #(
    parameter int BIT_DEPTH  = 64,
    parameter int BYTE_DEPTH = 8,
    localparam int PW = $clog2(BIT_DEPTH),
    localparam int FW = $clog2(BIT_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          byte_mode_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [1:0]    clr_i,
    output logic [PW-1:0] wptr_o,
    output logic [PW-1:0] rptr_o,
    output logic [FW-1:0] fill_o,
    output logic          wr_go_o,
    output logic          rd_go_o,
    output logic          ovf_o,
    output logic          unf_o
);

    logic [PW-1:0] wptr_q, rptr_q, ptr_mask, half_p;
    logic [FW-1:0] fill_q, depth_f, half_f;
    logic          ovf_q, unf_q;
    logic          full, empty, ovf_ev, unf_ev, wr_go, rd_go;

    // The active organisation sets the depth and the recentre distance.
    assign depth_f  = byte_mode_i ? FW'(BYTE_DEPTH)     : FW'(BIT_DEPTH);
    assign half_f   = byte_mode_i ? FW'(BYTE_DEPTH / 2) : FW'(BIT_DEPTH / 2);
    assign half_p   = byte_mode_i ? PW'(BYTE_DEPTH / 2) : PW'(BIT_DEPTH / 2);
    assign ptr_mask = byte_mode_i ? PW'(BYTE_DEPTH - 1) : PW'(BIT_DEPTH - 1);

    assign full  = (fill_q == depth_f);
    assign empty = (fill_q == '0);

    // Event classification for the cycle.
    assign ovf_ev = !flush_i && wr_en_i && full && !rd_en_i;
    assign unf_ev = !flush_i && rd_en_i && empty;
    assign wr_go  = !flush_i && wr_en_i && !ovf_ev && !unf_ev;
    assign rd_go  = !flush_i && rd_en_i && !unf_ev;

    // Pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else if (ovf_ev) begin
            rptr_q <= (wptr_q - half_p) & ptr_mask;
            fill_q <= half_f;
        end else if (unf_ev) begin
            wptr_q <= (rptr_q + half_p) & ptr_mask;
            fill_q <= half_f;
        end else begin
            if (wr_go) wptr_q <= (wptr_q + PW'(1)) & ptr_mask;
            if (rd_go) rptr_q <= (rptr_q + PW'(1)) & ptr_mask;
            if (wr_go && !rd_go)      fill_q <= fill_q + FW'(1);
            else if (rd_go && !wr_go) fill_q <= fill_q - FW'(1);
        end
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (ovf_ev)        ovf_q <= 1'b1;
            else if (clr_i[0]) ovf_q <= 1'b0;
            if (unf_ev)        unf_q <= 1'b1;
            else if (clr_i[1]) unf_q <= 1'b0;
        end
    end

    assign wptr_o  = wptr_q;
    assign rptr_o  = rptr_q;
    assign fill_o  = fill_q;
    assign wr_go_o = wr_go;
    assign rd_go_o = rd_go;
    assign ovf_o   = ovf_q;
    assign unf_o   = unf_q;

    // R5: the fill never exceeds the depth of the active organisation.
    p_fill_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= depth_f);

    // R5: an accepted write alone raises the fill by one.
    p_fill_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !rd_go) |=> (fill_q == $past(fill_q) + FW'(1)));

    // R3: overflow sets the flag and recentres the fill.
    p_ovf_recentre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> (ovf_q && fill_q == $past(half_f)));

    // R4: underflow sets the flag and recentres the fill.
    p_unf_recentre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unf_ev |=> (unf_q && fill_q == $past(half_f)));

    // R6: the overflow flag holds until cleared.
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i[0] && !flush_i) |=> ovf_q);

    // R6: the underflow flag holds until cleared.
    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !clr_i[1] && !flush_i) |=> unf_q);

    // R7: a flush empties the store and clears both flags.
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fill_q == '0 && !ovf_q && !unf_q));

endmodule

// File: rtl/tes_store.sv
module tes_store #(
    parameter int BIT_DEPTH = 64,
    parameter int BYTE_W    = 8,
    localparam int BYTE_DEPTH = BIT_DEPTH / BYTE_W,
    localparam int PW  = $clog2(BIT_DEPTH),
    localparam int BPW = $clog2(BYTE_DEPTH),
    localparam int LBW = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              byte_mode_i,
    input  logic              wr_go_i,
    input  logic              rd_go_i,
    input  logic [PW-1:0]     wptr_i,
    input  logic [PW-1:0]     rptr_i,
    input  logic              wr_bit_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              wr_mark_i,
    output logic              rd_bit_o,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic              rd_mark_o
);

    logic [BIT_DEPTH-1:0]  cells;
    logic [BYTE_DEPTH-1:0] marks;
    logic [PW-1:0]         rd_base;
    logic                  rd_bit_q, rd_mark_q;
    logic [BYTE_W-1:0]     rd_byte_q;

    // Each cell is bit i of the serial FIFO. It is also lane i%BYTE_W
    // of byte entry i/BYTE_W.
    for (genvar i = 0; i < BIT_DEPTH; i++) begin : g_cell
        localparam int LANE = i % BYTE_W;
        localparam int ENT  = i / BYTE_W;
        logic hit, cell_q;
        assign hit = byte_mode_i ? (wptr_i[BPW-1:0] == BPW'(ENT))
                                 : (wptr_i == PW'(i));
        always_ff @(posedge clk) begin
            if (wr_go_i && hit)
                cell_q <= byte_mode_i ? wr_byte_i[LANE] : wr_bit_i;
        end
        assign cells[i] = cell_q;
    end

    // One marker bit per byte entry.
    for (genvar e = 0; e < BYTE_DEPTH; e++) begin : g_mark
        logic mark_q;
        always_ff @(posedge clk) begin
            if (wr_go_i && byte_mode_i && wptr_i[BPW-1:0] == BPW'(e))
                mark_q <= wr_mark_i;
        end
        assign marks[e] = mark_q;
    end

    assign rd_base = {rptr_i[BPW-1:0], {LBW{1'b0}}};

    // Registered read port, updated only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            rd_bit_q  <= 1'b0;
            rd_byte_q <= '0;
            rd_mark_q <= 1'b0;
        end else if (rd_go_i) begin
            if (byte_mode_i) begin
                rd_byte_q <= cells[rd_base +: BYTE_W];
                rd_mark_q <= marks[rptr_i[BPW-1:0]];
            end else begin
                rd_bit_q  <= cells[rptr_i];
            end
        end
    end

    assign rd_bit_o  = rd_bit_q;
    assign rd_byte_o = rd_byte_q;
    assign rd_mark_o = rd_mark_q;

    // R9, R4: without an accepted read or a flush the read port holds.
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_go_i && !flush_i) |=> ($stable(rd_bit_q) && $stable(rd_byte_q)
                                   && $stable(rd_mark_q)));

    // R7: a flush zeroes the read port.
    p_rd_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!rd_bit_q && rd_byte_q == '0 && !rd_mark_q));

endmodule

// File: rtl/trib_elastic_store.sv
module trib_elastic_store
    import tes_pkg::*;
#(
    parameter int BIT_DEPTH = 64,
    parameter int BYTE_W    = 8,
    localparam int BYTE_DEPTH = BIT_DEPTH / BYTE_W,
    localparam int PW = $clog2(BIT_DEPTH),
    localparam int FW = $clog2(BIT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              wr_en_i,
    input  logic              wr_bit_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              wr_mark_i,
    input  logic              rd_en_i,
    input  logic [1:0]        clr_i,
    output logic              rd_bit_o,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic              rd_mark_o,
    output logic [FW-1:0]     fill_o,
    output logic              ovf_o,
    output logic              unf_o
);

    logic          flush, byte_mode, wr_go, rd_go;
    logic [PW-1:0] wptr, rptr;

    tes_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .flush_o     (flush),
        .byte_mode_o (byte_mode)
    );

    tes_ptr #(
        .BIT_DEPTH  (BIT_DEPTH),
        .BYTE_DEPTH (BYTE_DEPTH)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .byte_mode_i (byte_mode),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .clr_i       (clr_i),
        .wptr_o      (wptr),
        .rptr_o      (rptr),
        .fill_o      (fill_o),
        .wr_go_o     (wr_go),
        .rd_go_o     (rd_go),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o)
    );

    tes_store #(
        .BIT_DEPTH (BIT_DEPTH),
        .BYTE_W    (BYTE_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .byte_mode_i (byte_mode),
        .wr_go_i     (wr_go),
        .rd_go_i     (rd_go),
        .wptr_i      (wptr),
        .rptr_i      (rptr),
        .wr_bit_i    (wr_bit_i),
        .wr_byte_i   (wr_byte_i),
        .wr_mark_i   (wr_mark_i),
        .rd_bit_o    (rd_bit_o),
        .rd_byte_o   (rd_byte_o),
        .rd_mark_o   (rd_mark_o)
    );

    // R8: enables arriving during a flush never reach the store.
    p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!wr_go && !rd_go));

endmodule

// File: tb/test_trib_elastic_store.sv
module test_trib_elastic_store;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       wr_en = 1'b0, wr_bit = 1'b0, wr_mark = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic [1:0] clr = '0;
    logic       rd_bit, rd_mark, ovf, unf;
    logic [7:0] rd_byte;
    logic [6:0] fill;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    trib_elastic_store i_trib_elastic_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .wr_en_i   (wr_en),
        .wr_bit_i  (wr_bit),
        .wr_byte_i (wr_byte),
        .wr_mark_i (wr_mark),
        .rd_en_i   (rd_en),
        .clr_i     (clr),
        .rd_bit_o  (rd_bit),
        .rd_byte_o (rd_byte),
        .rd_mark_o (rd_mark),
        .fill_o    (fill),
        .ovf_o     (ovf),
        .unf_o     (unf)
    );

    function automatic logic pbit(int i);
        return logic'(((i * 11) + (i >> 5) + (i >> 2)) & 1);
    endfunction

    function automatic logic [7:0] pbyte(int i);
        return 8'((i * 37 + 91) ^ (i * i));
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs are read at the next one.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr1(logic b);
        wr_en = 1'b1; wr_bit = b; step(); wr_en = 1'b0;
    endtask

    task automatic wrb(logic [7:0] d, logic m);
        wr_en = 1'b1; wr_byte = d; wr_mark = m; step(); wr_en = 1'b0;
    endtask

    task automatic rd1();
        rd_en = 1'b1; step(); rd_en = 1'b0;
    endtask

    task automatic go_mode(logic [1:0] m);
        mode = m; step(); step();
    endtask

    task automatic fresh(logic [1:0] m);
        go_mode(m ^ 2'b01);
        go_mode(m);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        wr_en = 1'b1; wr_bit = 1'b1; rd_en = 1'b1;
        step();
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8", "fill after reset", int'(fill), 0);
        check("R8", "flags after reset", int'({ovf, unf}), 0);
        check("R8", "read outputs after reset", int'({rd_bit, rd_byte, rd_mark}), 0);
    endtask

    task automatic t_bit_fifo();
        int mism = 0;
        fresh(2'b00);
        for (int i = 0; i < 64; i++) wr1(pbit(i));
        check("R1", "fill when full", int'(fill), 64);
        rd1();
        check("R9", "first bit one edge after read", int'(rd_bit), int'(pbit(0)));
        check("R5", "fill after one read", int'(fill), 63);
        for (int i = 1; i < 64; i++) begin
            rd1();
            if (rd_bit != pbit(i)) mism++;
        end
        check("R1", "bit order mismatches", mism, 0);
        check("R1", "fill after draining", int'(fill), 0);
    endtask

    task automatic t_simul();
        fresh(2'b01);
        for (int i = 0; i < 3; i++) wr1(pbit(i + 1));
        wr_en = 1'b1; wr_bit = 1'b0; rd_en = 1'b1; step();
        wr_en = 1'b0; rd_en = 1'b0;
        check("R5", "fill on write with read", int'(fill), 3);
        check("R5", "bit read during concurrent write", int'(rd_bit), int'(pbit(1)));
        fresh(2'b00);
        for (int i = 0; i < 64; i++) wr1(1'b1);
        wr_en = 1'b1; rd_en = 1'b1; step();
        wr_en = 1'b0; rd_en = 1'b0;
        check("R3", "full with read and write: fill", int'(fill), 64);
        check("R3", "full with read and write: no overflow", int'(ovf), 0);
    endtask

    task automatic t_bit_ovf();
        fresh(2'b00);
        for (int i = 0; i < 64; i++) wr1(pbit(i));
        wr1(1'b1);
        check("R3", "overflow flag", int'(ovf), 1);
        check("R3", "fill after overflow recentre", int'(fill), 32);
        rd1();
        check("R3", "resume bit after overflow", int'(rd_bit), int'(pbit(32)));
    endtask

    task automatic t_unf();
        fresh(2'b00);
        wr1(1'b1);
        rd1();
        check("R9", "bit read back", int'(rd_bit), 1);
        wr_en = 1'b1; wr_bit = 1'b0; rd_en = 1'b1; step();
        wr_en = 1'b0; rd_en = 1'b0;
        check("R4", "underflow flag", int'(unf), 1);
        check("R4", "fill after underflow recentre", int'(fill), 32);
        check("R4", "read output held on underflow", int'(rd_bit), 1);
        fresh(2'b10);
        rd1();
        check("R4", "byte mode underflow fill", int'(fill), 4);
        check("R4", "byte mode read held at zero", int'(rd_byte), 0);
    endtask

    task automatic t_byte();
        int mism = 0;
        fresh(2'b10);
        for (int i = 0; i < 8; i++) wrb(pbyte(i), (i == 3) || (i == 6));
        check("R2", "byte fill when full", int'(fill), 8);
        for (int i = 0; i < 8; i++) begin
            rd1();
            if (rd_byte != pbyte(i) || rd_mark != ((i == 3) || (i == 6))) mism++;
            if (i == 3) check("R2", "marker on tagged byte", int'(rd_mark), 1);
        end
        check("R2", "byte and marker mismatches", mism, 0);
        fresh(2'b11);
        for (int i = 0; i < 8; i++) wrb(pbyte(i + 20), i == 4);
        wrb(8'hFF, 1'b0);
        check("R3", "byte overflow flag", int'(ovf), 1);
        check("R3", "byte fill after overflow", int'(fill), 4);
        rd1();
        check("R3", "byte resume after overflow", int'(rd_byte), int'(pbyte(24)));
        check("R3", "marker resume after overflow", int'(rd_mark), 1);
    endtask

    task automatic t_clear();
        fresh(2'b00);
        rd1();
        repeat (3) step();
        check("R6", "underflow flag sticky", int'(unf), 1);
        clr = 2'b01; step(); clr = 2'b00;
        check("R6", "wrong clear bit leaves underflow", int'(unf), 1);
        clr = 2'b10; step(); clr = 2'b00;
        check("R6", "underflow cleared by bit 1", int'(unf), 0);
        fresh(2'b00);
        rd_en = 1'b1; clr = 2'b10; step(); rd_en = 1'b0; clr = 2'b00;
        check("R6", "set wins over clear", int'(unf), 1);
        fresh(2'b00);
        for (int i = 0; i < 65; i++) wr1(1'b0);
        clr = 2'b01; step(); clr = 2'b00;
        check("R6", "overflow cleared by bit 0", int'(ovf), 0);
    endtask

    task automatic t_mode();
        fresh(2'b00);
        wr1(1'b1);
        rd1();
        rd1();
        mode = 2'b10; wr_en = 1'b1; wr_byte = 8'hA5; step();
        step(); wr_en = 1'b0;
        check("R7", "fill after mode change", int'(fill), 0);
        check("R7", "flags after mode change", int'({ovf, unf}), 0);
        check("R7", "read bit zeroed", int'(rd_bit), 0);
        wrb(8'h5A, 1'b1);
        check("R7", "store runs after flush", int'(fill), 1);
        go_mode(2'b00);
        wr1(1'b1); wr1(1'b1);
        mode = 2'b01; step(); step();
        check("R7", "async to bit-sync flush", int'(fill), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_bit_fifo();
        t_simul();
        t_bit_ovf();
        t_unf();
        t_byte();
        t_clear();
        t_mode();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule